// File: doc/BRIEF.md
# Timed Key Combination Detector

This block watches a small group of active-low key inputs that have already been synchronized to the local clock. Each of several independent combination slots selects a subset of those keys through a mask. When every selected key is pressed (driven low) and stays pressed for a programmed number of ticks of a slow timebase, the slot detects the combination and fires the actions enabled for it.

Three kinds of action exist: a sticky interrupt status bit with an interrupt line, a stretched active-low reset pulse whose width in ticks is programmable, and a set of auxiliary action strobes for neighbouring logic. A slot fires once per press. Releasing any selected key re-arms it. Status bits stay set until software writes a 1 to clear them.

Top module: `key_combo_det`

## Requirements
- R1: After reset, all status bits are 0, `irq_o` is 0, `rst_out_n` is 1 and `aux_o` is all zeros.
- R2: A slot with a non-zero mask detects on the N-th tick seen after all its selected keys have been low for at least one clock, with N = max(duration, 1). Its status bit reads 1 in the cycle after the detecting tick.
- R3: If any selected key goes high (released) before N ticks, the tick count is discarded. A later press needs a full N ticks again.
- R4: A slot fires at most once per press. Further ticks while the keys stay held do not set it again. A release followed by a new press re-arms it.
- R5: A slot whose mask is all zeros never fires, whatever the keys do.
- R6: Keys outside a slot's mask have no effect on it: pressing extra keys does not block detection, and pressing all but one selected key never fires.
- R7: Status bits are sticky and clear when the matching `status_clr` bit is 1. A detection in the same cycle as a clear leaves the bit set.
- R8: `irq_o` is 1 exactly when some status bit is set whose slot has action bit 0 (interrupt enable) set.
- R9: A detection on a slot with action bit 1 set drives `rst_out_n` low from the next cycle for exactly max(width, 1) ticks. Without action bit 1, `rst_out_n` stays high.
- R10: Action bits 2 and up map to `aux_o` bits 0 and up. Each enabled bit goes high for exactly one clock cycle after a detection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timebase strobe |
| keys_n | input | NUM_KEYS | Synchronized keys, 0 = pressed |
| combo_mask | input | NUM_COMBOS x NUM_KEYS | Key selection per slot |
| combo_dur | input | NUM_COMBOS x DUR_W | Hold time per slot, in ticks |
| combo_act | input | NUM_COMBOS x ACT_W | Action enables per slot (bit 0 irq, bit 1 reset, others aux) |
| pulse_width | input | PW_W | Reset pulse width in ticks |
| status_clr | input | NUM_COMBOS | Write-1-to-clear strobe per status bit |
| status | output | NUM_COMBOS | Sticky detection status |
| irq_o | output | 1 | Interrupt request |
| rst_out_n | output | 1 | Active-low reset pulse |
| aux_o | output | ACT_W-2 | Auxiliary action strobes |

## Verification
Assertions check on every cycle the properties that can be stated locally. A release always returns a slot timer to idle. A latched slot stays latched while held. A detection always follows a held cycle. A set status bit always wins over a clear, and status never rises without a set. A load always drives the reset output low, and the pulse counter is frozen between ticks. The exact tick on which a slot fires, the re-arm on release, the masking of keys and the full length of the reset pulse need scripted sequences. The bench covers these by sweeping duration, every mask of four keys, and pulse widths, and computes the expected tick counts arithmetically.

// File: rtl/kcd_pkg.sv
package kcd_pkg;

    localparam int ACT_IRQ    = 0;
    localparam int ACT_RST    = 1;
    localparam int ACT_AUX_LO = 2;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_LATCHED = 2'd2
    } kcd_state_e;

    // True when the mask is non-empty and every masked key is pressed.
    function automatic logic keys_all_held(input logic [31:0] pressed,
                                           input logic [31:0] mask);
        return (mask != 32'd0) && ((pressed & mask) == mask);
    endfunction

endpackage

// File: rtl/kcd_combo_timer.sv
module kcd_combo_timer
    import kcd_pkg::*;
#(
    parameter int NUM_KEYS = 4,
    parameter int DUR_W    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic [NUM_KEYS-1:0] keys_n,
    input  logic [NUM_KEYS-1:0] mask,
    input  logic [DUR_W-1:0]    dur,
    output logic                hit
);
    localparam int CW = DUR_W + 1;

    kcd_state_e       state;
    logic [DUR_W-1:0] cnt;
    logic             active;
    logic             reached;

    always_comb begin
        active  = keys_all_held(32'(~keys_n), 32'(mask));
        reached = (CW'(cnt) + CW'(1)) >= CW'(dur);
        hit     = (state == ST_COUNT) && active && tick && reached;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (active) state <= ST_COUNT;
                end
                ST_COUNT: begin
                    if (!active) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else if (hit) begin
                        state <= ST_LATCHED;
                    end else if (tick) begin
                        cnt <= cnt + DUR_W'(1);
                    end
                end
                ST_LATCHED: begin
                    if (!active) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_release_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !active |=> state == ST_IDLE);

    p_latched_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LATCHED && active) |=> state == ST_LATCHED);

    p_fire_after_hold_r2: assert property (@(posedge clk) disable iff (rst)
        hit |-> $past(active));

endmodule

// File: rtl/kcd_pulse_stretch.sv
module kcd_pulse_stretch #(
    parameter int PW_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            load,
    input  logic [PW_W-1:0] width,
    output logic            rst_out_n
);
    logic [PW_W-1:0] pcnt;
    logic [PW_W-1:0] pcnt_nx;

    always_comb begin
        pcnt_nx = pcnt;
        if (load)
            pcnt_nx = (width == '0) ? PW_W'(1) : width;
        else if (tick && pcnt != '0)
            pcnt_nx = pcnt - PW_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt      <= '0;
            rst_out_n <= 1'b1;
        end else begin
            pcnt      <= pcnt_nx;
            rst_out_n <= (pcnt_nx == '0);
        end
    end

    p_load_low_r9: assert property (@(posedge clk) disable iff (rst)
        load |=> !rst_out_n);

    p_frozen_between_ticks_r9: assert property (@(posedge clk) disable iff (rst)
        (!load && !tick) |=> $stable(pcnt));

    p_stays_released_r9: assert property (@(posedge clk) disable iff (rst)
        (rst_out_n && !load) |=> rst_out_n);

endmodule

// File: rtl/kcd_status.sv
module kcd_status #(
    parameter int NUM_COMBOS = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_COMBOS-1:0] set,
    input  logic [NUM_COMBOS-1:0] clr,
    output logic [NUM_COMBOS-1:0] status
);
    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clr) | set;
    end

    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & $past(set)) == $past(set)));

    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & $past(status & ~clr)) == $past(status & ~clr)));

    p_no_spurious_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & ~$past(status) & ~$past(set)) == '0));

endmodule

// File: rtl/key_combo_det.sv
module key_combo_det
    import kcd_pkg::*;
#(
    parameter int NUM_KEYS   = 4,
    parameter int NUM_COMBOS = 2,
    parameter int DUR_W      = 8,
    parameter int PW_W       = 8,
    parameter int ACT_W      = 4
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 tick,
    input  logic [NUM_KEYS-1:0]                  keys_n,
    input  logic [NUM_COMBOS-1:0][NUM_KEYS-1:0]  combo_mask,
    input  logic [NUM_COMBOS-1:0][DUR_W-1:0]     combo_dur,
    input  logic [NUM_COMBOS-1:0][ACT_W-1:0]     combo_act,
    input  logic [PW_W-1:0]                      pulse_width,
    input  logic [NUM_COMBOS-1:0]                status_clr,
    output logic [NUM_COMBOS-1:0]                status,
    output logic                                 irq_o,
    output logic                                 rst_out_n,
    output logic [ACT_W-3:0]                     aux_o
);
    localparam int AUX_W = ACT_W - ACT_AUX_LO;

    logic [NUM_COMBOS-1:0] hit;
    logic                  rst_load;
    logic [AUX_W-1:0]      aux_nx;

    for (genvar g = 0; g < NUM_COMBOS; g++) begin : g_slot
        kcd_combo_timer #(
            .NUM_KEYS (NUM_KEYS),
            .DUR_W    (DUR_W)
        ) timer_i (
            .clk    (clk),
            .rst    (rst),
            .tick   (tick),
            .keys_n (keys_n),
            .mask   (combo_mask[g]),
            .dur    (combo_dur[g]),
            .hit    (hit[g])
        );
    end

    always_comb begin
        rst_load = 1'b0;
        aux_nx   = '0;
        irq_o    = 1'b0;
        for (int i = 0; i < NUM_COMBOS; i++) begin
            rst_load = rst_load | (hit[i] & combo_act[i][ACT_RST]);
            irq_o    = irq_o | (status[i] & combo_act[i][ACT_IRQ]);
            if (hit[i]) aux_nx = aux_nx | combo_act[i][ACT_W-1:ACT_AUX_LO];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) aux_o <= '0;
        else     aux_o <= aux_nx;
    end

    kcd_status #(
        .NUM_COMBOS (NUM_COMBOS)
    ) status_i (
        .clk    (clk),
        .rst    (rst),
        .set    (hit),
        .clr    (status_clr),
        .status (status)
    );

    kcd_pulse_stretch #(
        .PW_W (PW_W)
    ) pulse_i (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .load      (rst_load),
        .width     (pulse_width),
        .rst_out_n (rst_out_n)
    );

    p_aux_one_cycle_r10: assert property (@(posedge clk) disable iff (rst)
        (aux_o != '0 && hit == '0) |=> aux_o == '0);

    p_masked_zero_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (combo_mask == '0) |=> $stable(status) || ((status & ~$past(status)) == '0));

endmodule

// File: tb/key_combo_det_tb.sv
module key_combo_det_tb_top;
    localparam int CLK_P = 10;
    localparam int NK = 4;
    localparam int NC = 2;
    localparam int DW = 4;
    localparam int PW = 4;
    localparam int AW = 4;

    logic                     clk = 1'b0;
    logic                     rst;
    logic                     tick;
    logic [NK-1:0]            keys_n;
    logic [NC-1:0][NK-1:0]    combo_mask;
    logic [NC-1:0][DW-1:0]    combo_dur;
    logic [NC-1:0][AW-1:0]    combo_act;
    logic [PW-1:0]            pulse_width;
    logic [NC-1:0]            status_clr;
    logic [NC-1:0]            status;
    logic                     irq_o;
    logic                     rst_out_n;
    logic [AW-3:0]            aux_o;

    int total = 0;
    int bad   = 0;

    always #(CLK_P/2) clk = ~clk;

    key_combo_det #(
        .NUM_KEYS(NK), .NUM_COMBOS(NC), .DUR_W(DW), .PW_W(PW), .ACT_W(AW)
    ) dut_i (
        .clk(clk), .rst(rst), .tick(tick), .keys_n(keys_n),
        .combo_mask(combo_mask), .combo_dur(combo_dur), .combo_act(combo_act),
        .pulse_width(pulse_width), .status_clr(status_clr), .status(status),
        .irq_o(irq_o), .rst_out_n(rst_out_n), .aux_o(aux_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tk();
        tick = 1'b1;
        step();
        tick = 1'b0;
    endtask

    task automatic clr_all();
        status_clr = '1;
        step();
        status_clr = '0;
    endtask

    task automatic press(input logic [NK-1:0] pressed);
        keys_n = ~pressed;
        step();
    endtask

    task automatic fresh();
        keys_n = '1;
        step();
        clr_all();
    endtask

    initial begin
        #(CLK_P * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; tick = 1'b0; keys_n = '1; combo_mask = '0; combo_dur = '0;
        combo_act = '0; pulse_width = '0; status_clr = '0;
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset state
        chk("R1", "status", 32'(status), 0);
        chk("R1", "irq", 32'(irq_o), 0);
        chk("R1", "rst_out_n", 32'(rst_out_n), 1);
        chk("R1", "aux", 32'(aux_o), 0);

        // R2 duration sweep on slot 0, irq only; R8 irq; R9 no reset pulse
        combo_mask[0] = 4'b0011;
        combo_act[0]  = 4'b0001;
        for (int d = 0; d <= 7; d++) begin
            int n;
            n = (d == 0) ? 1 : d;
            combo_dur[0] = DW'(d);
            fresh();
            press(4'b0011);
            for (int k = 0; k < n - 1; k++) tk();
            chk("R2", $sformatf("before fire d=%0d", d), 32'(status[0]), 0);
            tk();
            chk("R2", $sformatf("fire d=%0d", d), 32'(status[0]), 1);
            chk("R8", "irq on", 32'(irq_o), 1);
            chk("R9", "no pulse without action", 32'(rst_out_n), 1);
        end

        // R3 release before expiry restarts the count
        combo_dur[0] = 4'd4;
        fresh();
        press(4'b0011);
        tk(); tk(); tk();
        press(4'b0001);
        press(4'b0011);
        tk(); tk(); tk();
        chk("R3", "restart needs full count", 32'(status[0]), 0);
        tk();
        chk("R3", "fire after full count", 32'(status[0]), 1);

        // R4 once per press, re-arm on release
        clr_all();
        for (int k = 0; k < 10; k++) tk();
        chk("R4", "no refire while held", 32'(status[0]), 0);
        press(4'b0010);
        press(4'b0011);
        for (int k = 0; k < 4; k++) tk();
        chk("R4", "refire after re-arm", 32'(status[0]), 1);

        // R7 clear works, set beats clear
        clr_all();
        chk("R7", "cleared", 32'(status[0]), 0);
        chk("R8", "irq off", 32'(irq_o), 0);
        combo_dur[0] = 4'd2;
        fresh();
        press(4'b0011);
        tk();
        status_clr = 2'b01;
        tick = 1'b1;
        step();
        tick = 1'b0;
        status_clr = '0;
        chk("R7", "set wins", 32'(status[0]), 1);
        step(); step();
        chk("R7", "sticky", 32'(status[0]), 1);

        // R5 zero mask never fires
        combo_mask[0] = '0;
        fresh();
        press('1);
        for (int k = 0; k < 20; k++) tk();
        chk("R5", "zero mask", 32'(status), 0);

        // R6 exhaustive mask sweep, duration 1
        combo_dur[0] = 4'd1;
        for (int m = 1; m < 16; m++) begin
            logic [NK-1:0] mm, low, part;
            mm = NK'(m);
            low = mm & (~mm + NK'(1));
            part = ~mm | (mm & ~low);
            combo_mask[0] = mm;
            fresh();
            press('1);
            tk();
            chk("R6", $sformatf("extra keys m=%0h", m), 32'(status[0]), 1);
            fresh();
            press(part);
            tk(); tk();
            chk("R6", $sformatf("one missing m=%0h", m), 32'(status[0]), 0);
        end

        // R9 reset pulse width sweep on slot 1; R8 irq stays low
        combo_mask[0] = '0;
        combo_mask[1] = 4'b1100;
        combo_dur[1]  = 4'd2;
        combo_act[1]  = 4'b0010;
        for (int w = 0; w <= 6; w++) begin
            int n;
            n = (w == 0) ? 1 : w;
            pulse_width = PW'(w);
            fresh();
            press(4'b1100);
            tk();
            chk("R9", "high before fire", 32'(rst_out_n), 1);
            tk();
            chk("R9", $sformatf("low after fire w=%0d", w), 32'(rst_out_n), 0);
            chk("R8", "irq masked", 32'(irq_o), 0);
            for (int k = 0; k < n - 1; k++) tk();
            chk("R9", $sformatf("still low w=%0d", w), 32'(rst_out_n), 0);
            tk();
            chk("R9", $sformatf("released w=%0d", w), 32'(rst_out_n), 1);
        end

        // R10 aux strobes
        combo_act[1] = 4'b1100;
        combo_dur[1] = 4'd1;
        fresh();
        press(4'b1100);
        tk();
        chk("R10", "aux high", 32'(aux_o), 3);
        chk("R10", "no reset pulse", 32'(rst_out_n), 1);
        step();
        chk("R10", "aux one cycle", 32'(aux_o), 0);
        combo_act[1] = 4'b0100;
        fresh();
        press(4'b1100);
        tk();
        chk("R10", "aux single bit", 32'(aux_o), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule